// File: doc/BRIEF.md
# Power Management Timer with Carry Status

This block is a free-running power management timer. A counter, 24 or 32 bits wide by parameter, advances by one on every cycle in which the fixed-rate tick strobe is high. It advances only while the system sleep state is working (S0) or light sleep (S1). In all deeper states it freezes, and it resumes from the same value when the system returns to S0 or S1. Software reads the count directly from the block's output. The tick strobe is a single-cycle pulse already in the block's clock domain. At about 3.58 MHz, a 24-bit counter flips its top bit roughly every 2.34 seconds.

Each time the counter's top bit changes, in either direction, a sticky carry status flag is set. This gives an event every half period of the counter. Software clears the flag by writing a one to it. A separate enable flag is written by software. While both flags are set, a level interrupt is driven out of the block. The width parameter accepts any value of 4 or more. The 24-bit and 32-bit settings are the production ones. A narrower setting shortens simulation.

Top module: `pm_timer_top`

## Requirements
- R1: After reset the count, the carry status flag, the enable flag and the interrupt are all zero.
- R2: When `tick_i` is high and `sleep_i` is 0 (S0) or 1 (S1) at a clock edge, `count_o` shows the old value plus one from that edge on.
- R3: A clock edge with `tick_i` low leaves `count_o` unchanged.
- R4: When `sleep_i` is any code from 2 to 7 (S2 to S5 and unused codes), `count_o` holds its value even with `tick_i` high.
- R5: When the count's top bit (bit CNT_W-1) goes from 0 to 1, `sts_o` is high starting one clock edge after the edge at which the count changed.
- R6: The count wraps from all ones to zero. That wrap moves the top bit from 1 to 0 and sets `sts_o` with the same timing as R5.
- R7: `sts_o` stays set until a clock edge with `sts_clr_i` high, after which it reads 0. A clear while `sts_o` is 0 leaves it at 0.
- R8: If a top-bit change and a clear reach the status flag at the same edge, `sts_o` stays 1.
- R9: A clock edge with `en_wr_i` high loads `en_val_i` into `en_o`. Without `en_wr_i`, `en_o` keeps its value whatever `en_val_i` does.
- R10: `irq_o` goes high one clock edge after `sts_o` and `en_o` are both 1. It falls one edge after either flag drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Single-cycle count strobe from the fixed-rate tick |
| sleep_i | input | 3 | System sleep state code: 0 = S0, 1 = S1, 2 to 5 = S2 to S5 |
| count_o | output | CNT_W | Current counter value |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the carry status flag |
| en_wr_i | input | 1 | Enable flag write strobe |
| en_val_i | input | 1 | Value written to the enable flag |
| sts_o | output | 1 | Sticky carry status flag |
| en_o | output | 1 | Interrupt enable flag |
| irq_o | output | 1 | Interrupt level: status and enable both set |

## Verification
A top-bit change of the counter and a software clear of the status flag can reach the flag at the same clock edge. The bench provokes this by ending a tick burst exactly at the top-bit change. On the very next cycle it raises `sts_clr_i`, which is the cycle in which the registered carry pulse reaches the flag. The bench judges the outcome by checking that `sts_o` is still 1 afterwards. It then compares this against a plain clear on a quiet cycle, which must drop the flag.

// File: rtl/pm_tmr_pkg.sv
`timescale 1ns/1ps
package pm_tmr_pkg;

  localparam int SLP_W = 3;

  typedef enum logic [SLP_W-1:0] {
    SLP_WORK  = 3'd0,
    SLP_LIGHT = 3'd1,
    SLP_S2    = 3'd2,
    SLP_S3    = 3'd3,
    SLP_S4    = 3'd4,
    SLP_OFF   = 3'd5
  } slp_state_e;

  // The counter runs only in the working and light-sleep states.
  function automatic logic slp_runs(input logic [SLP_W-1:0] s);
    return (s == SLP_WORK) || (s == SLP_LIGHT);
  endfunction

endpackage

// File: rtl/pm_tmr_counter.sv
`timescale 1ns/1ps
module pm_tmr_counter
  import pm_tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [SLP_W-1:0] sleep_i,
  output logic [CNT_W-1:0] count_o,
  output logic             carry_o
);

  localparam int               MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nx;
  logic             adv;
  logic             carry_q;

  assign adv      = tick_i && slp_runs(sleep_i);
  assign count_nx = count_q + ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= adv && (count_nx[MSB] ^ count_q[MSB]);
      if (adv) count_q <= count_nx;
    end
  end

  assign count_o = count_q;
  assign carry_o = carry_q;

  // R2: an accepted tick steps the count by one
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tick_i && slp_runs(sleep_i)) |=> count_q == $past(count_q) + ONE);

  // R3 / R4: no tick or a deep sleep state freezes the count
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(tick_i && slp_runs(sleep_i)) |=> $stable(count_q));

  // R5 / R6: every top-bit change yields a carry pulse
  assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (count_q[MSB] != $past(count_q[MSB])) |-> carry_q);

endmodule

// File: rtl/pm_tmr_status.sv
`timescale 1ns/1ps
module pm_tmr_status (
  input  logic clk,
  input  logic rst,
  input  logic carry_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  output logic sts_o,
  output logic en_o
);

  logic sts_q;
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      // A new carry wins over a clear arriving at the same edge.
      if (carry_i)    sts_q <= 1'b1;
      else if (clr_i) sts_q <= 1'b0;
      if (en_wr_i) en_q <= en_val_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;

  // R7: the flag is sticky without a clear
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (sts_q && !clr_i) |=> sts_q);

  // R7: a clear on a quiet cycle drops the flag
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !carry_i) |=> !sts_q);

  // R8: a carry always leaves the flag set
  assert_setwins_R8: assert property (@(posedge clk) disable iff (rst)
    carry_i |=> sts_q);

  // R9: the enable flag holds without a write strobe
  assert_en_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !en_wr_i |=> $stable(en_q));

endmodule

// File: rtl/pm_tmr_irq.sv
`timescale 1ns/1ps
module pm_tmr_irq (
  input  logic clk,
  input  logic rst,
  input  logic sts_i,
  input  logic en_i,
  output logic irq_o
);

  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= sts_i && en_i;
  end

  assign irq_o = irq_q;

  // R10: the interrupt follows both flags with one edge of delay
  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
    (sts_i && en_i) |=> irq_q);

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (rst)
    !(sts_i && en_i) |=> !irq_q);

endmodule

// File: rtl/pm_timer_top.sv
`timescale 1ns/1ps
module pm_timer_top
  import pm_tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [SLP_W-1:0] sleep_i,
  output logic [CNT_W-1:0] count_o,
  input  logic             sts_clr_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  output logic             sts_o,
  output logic             en_o,
  output logic             irq_o
);

  logic carry;
  logic sts;
  logic en;

  pm_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .sleep_i (sleep_i),
    .count_o (count_o),
    .carry_o (carry)
  );

  pm_tmr_status u_sts (
    .clk      (clk),
    .rst      (rst),
    .carry_i  (carry),
    .clr_i    (sts_clr_i),
    .en_wr_i  (en_wr_i),
    .en_val_i (en_val_i),
    .sts_o    (sts),
    .en_o     (en)
  );

  pm_tmr_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .sts_i (sts),
    .en_i  (en),
    .irq_o (irq_o)
  );

  assign sts_o = sts;
  assign en_o  = en;

  // R1: reset leaves every output cleared
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && !sts_o && !en_o && !irq_o));

endmodule

// File: tb/pm_timer_top_test.sv
`timescale 1ns/1ps
module pm_timer_top_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_i = 1'b0;
  logic [2:0]   sleep_i = 3'd0;
  logic [W-1:0] count_o;
  logic         sts_clr_i = 1'b0;
  logic         en_wr_i = 1'b0;
  logic         en_val_i = 1'b0;
  logic         sts_o;
  logic         en_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pm_timer_top #(.CNT_W(W)) uut (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .sleep_i   (sleep_i),
    .count_o   (count_o),
    .sts_clr_i (sts_clr_i),
    .en_wr_i   (en_wr_i),
    .en_val_i  (en_val_i),
    .sts_o     (sts_o),
    .en_o      (en_o),
    .irq_o     (irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    cyc(n);
    tick_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 count", count_o, 0);
    chk("R1 sts", sts_o, 0);
    chk("R1 en", en_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_count;
    sleep_i = 3'd0;
    ticks(10);
    chk("R2 count in S0", count_o, 10);
    sleep_i = 3'd1;
    ticks(5);
    chk("R2 count in S1", count_o, 15);
  endtask

  task automatic t_idle;
    cyc(7);
    chk("R3 no tick hold", count_o, 15);
  endtask

  task automatic t_sleep;
    for (int s = 2; s < 8; s++) begin
      sleep_i = 3'(s);
      ticks(9);
      chk("R4 deep sleep hold", count_o, 15);
    end
    sleep_i = 3'd0;
  endtask

  task automatic t_rise;
    ticks(112);
    cyc(2);
    chk("R5 count before flip", count_o, 127);
    chk("R5 sts before flip", sts_o, 0);
    ticks(1);
    chk("R5 count at flip", count_o, 128);
    cyc(1);
    chk("R5 sts after rise", sts_o, 1);
  endtask

  task automatic t_clear;
    sts_clr_i = 1'b1;
    cyc(1);
    sts_clr_i = 1'b0;
    chk("R7 clear drops sts", sts_o, 0);
    sts_clr_i = 1'b1;
    cyc(1);
    sts_clr_i = 1'b0;
    chk("R7 clear while low", sts_o, 0);
    ticks(20);
    cyc(2);
    chk("R7 no flip no set", sts_o, 0);
  endtask

  task automatic t_irq;
    en_val_i = 1'b1;
    en_wr_i  = 1'b1;
    cyc(1);
    en_wr_i  = 1'b0;
    en_val_i = 1'b0;
    chk("R9 enable written", en_o, 1);
    cyc(3);
    chk("R9 enable held", en_o, 1);
    chk("R10 irq low sts low", irq_o, 0);
    ticks(107);
    chk("R6 all ones", count_o, 255);
    ticks(1);
    chk("R6 wrap to zero", count_o, 0);
    cyc(1);
    chk("R6 sts on fall", sts_o, 1);
    chk("R10 irq lags sts", irq_o, 0);
    cyc(1);
    chk("R10 irq high", irq_o, 1);
    sts_clr_i = 1'b1;
    cyc(1);
    sts_clr_i = 1'b0;
    chk("R10 irq one edge after clear", irq_o, 1);
    cyc(1);
    chk("R10 irq low after clear", irq_o, 0);
  endtask

  task automatic t_collide;
    ticks(127);
    chk("R8 count before flip", count_o, 127);
    chk("R8 sts before flip", sts_o, 0);
    ticks(1);
    sts_clr_i = 1'b1;
    cyc(1);
    sts_clr_i = 1'b0;
    chk("R8 set wins over clear", sts_o, 1);
    cyc(1);
    chk("R10 irq from collided flag", irq_o, 1);
    en_val_i = 1'b1;
    en_wr_i  = 1'b1;
    en_val_i = 1'b0;
    cyc(1);
    en_wr_i = 1'b0;
    chk("R9 enable cleared", en_o, 0);
    en_val_i = 1'b1;
    cyc(3);
    chk("R9 value without strobe ignored", en_o, 0);
    chk("R10 irq low when disabled", irq_o, 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_reset;
    t_count;
    t_idle;
    t_sleep;
    t_rise;
    t_clear;
    t_irq;
    t_collide;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule